// File: doc/BRIEF.md
# SCSI Control-Line Set/Clear Executor

This block carries out the set/clear control-line instruction of a script-driven parallel SCSI controller. Each instruction arrives already decoded. It has an operation class (set or clear), a first-word control field, and a 32-bit second word. The block keeps a small output control latch with one bit for the ACK line and one bit for the ATN line. It updates only the bits that the control field flags. It drives the active-low bus ACK and ATN outputs from the latch, but only while the controller acts as initiator or loopback is enabled.

The same instruction also produces the address of the next instruction to fetch. When the selection or reselection attempt has failed, the next address is the branch target. In absolute mode that target is the second word as given. In relative mode it is the low 24 bits of the second word, sign-extended and added to the current script pointer. When the attempt has not failed, the next address is the sequential one, eight bytes past the current pointer.

The instruction takes effect on the clock edge where the execute strobe is high. A done pulse follows one cycle later, and all results hold until the next instruction.

Top module: `ctl_line_exec`

## Requirements
- R1: After reset, both latch bits are 0, both bus outputs are 1 (deasserted), `done_o` is 0 and `next_addr_o` is 0.
- R2: A set instruction (`op_set_i`=1) executed with control bit 6 high sets the ACK latch bit, and with control bit 3 high sets the ATN latch bit. Both bits may be flagged in one instruction.
- R3: A clear instruction (`op_set_i`=0) clears the ACK latch bit when control bit 6 is high and clears the ATN latch bit when control bit 3 is high.
- R4: A latch bit whose select bit (6 for ACK, 3 for ATN) is low keeps its value. Control bits 8:7, 5:4 and 2:0 have no effect on the latch.
- R5: Without the execute strobe the latch and `next_addr_o` keep their values.
- R6: The bus outputs are active-low. `ack_n_o` equals the inverse of the ACK latch bit and `atn_n_o` equals the inverse of the ATN latch bit while `initiator_i` or `loopback_i` is 1. Otherwise both outputs are 1, and the latch still updates.
- R7: `done_o` is 1 exactly in the cycle after a cycle with the execute strobe high.
- R8: An instruction with `fail_i`=1 and `rel_mode_i`=0 loads `next_addr_o` with the full second word.
- R9: An instruction with `fail_i`=1 and `rel_mode_i`=1 loads `next_addr_o` with `script_ptr_i` plus bits 23:0 of the second word sign-extended from bit 23, modulo 2^32.
- R10: An instruction with `fail_i`=0 loads `next_addr_o` with `script_ptr_i`+8, modulo 2^32.
- R11: A set instruction with only bit 3 flagged, followed by a clear instruction with only bit 6 flagged, leaves ATN asserted and ACK deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | One-cycle execute strobe |
| op_set_i | input | 1 | 1 = set, 0 = clear |
| ctl_bits_i | input | 9 | First-word control field; bit 6 selects ACK, bit 3 selects ATN |
| addr_word_i | input | 32 | Second instruction word |
| rel_mode_i | input | 1 | 1 = relative addressing of the branch target |
| script_ptr_i | input | 32 | Current script pointer |
| fail_i | input | 1 | Selection/reselection failed; sampled with the strobe |
| initiator_i | input | 1 | Controller is in initiator role |
| loopback_i | input | 1 | Loopback enable |
| ack_n_o | output | 1 | Bus ACK, active-low |
| atn_n_o | output | 1 | Bus ATN, active-low |
| latch_ack_o | output | 1 | ACK bit of the output control latch |
| latch_atn_o | output | 1 | ATN bit of the output control latch |
| next_addr_o | output | 32 | Next instruction fetch address |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions check the following on every cycle:
- the done pulse timing;
- that the latch and address hold when no instruction runs;
- that the bus outputs are gated off outside initiator role and loopback;
- the per-line set, clear and hold rules;
- the sequential address.

Only the bench scenarios show the rest:
- that the reserved control bits are ignored;
- the sign-extended relative branch arithmetic, including wrap past 2^32;
- the ATN-before-ACK ordering.

The bench compares every instruction against its own model over random role, loopback, selection and offset patterns.

// File: rtl/ctl_exec_pkg.sv
package ctl_exec_pkg;
    localparam int ADDR_W  = 32;
    localparam int CTL_W   = 9;
    localparam int LINE_N  = 2;
    localparam int LN_ACK  = 0;
    localparam int LN_ATN  = 1;
    // select bit position in the control field, per line index
    localparam int SEL_POS [LINE_N] = '{6, 3};

    typedef logic [LINE_N-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t          latch;
        logic [ADDR_W-1:0]  next_addr;
        logic               done;
    } exec_state_t;
endpackage

// File: rtl/ctl_latch_upd.sv
module ctl_latch_upd
    import ctl_exec_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_bits,
    input  logic             op_set,
    input  logic             apply,
    input  line_vec_t        cur,
    output line_vec_t        nxt
);
    for (genvar g = 0; g < LINE_N; g++) begin : g_line
        logic sel;
        assign sel    = apply & ctl_bits[SEL_POS[g]];
        assign nxt[g] = sel ? op_set : cur[g];
    end
endmodule

// File: rtl/bus_drv_gate.sv
module bus_drv_gate
    import ctl_exec_pkg::*;
(
    input  line_vec_t latch,
    input  logic      initiator,
    input  logic      loopback,
    output line_vec_t bus_n
);
    logic drive_en;
    assign drive_en = initiator | loopback;

    for (genvar g = 0; g < LINE_N; g++) begin : g_drv
        assign bus_n[g] = ~(latch[g] & drive_en);
    end
endmodule

// File: rtl/branch_addr_calc.sv
module branch_addr_calc #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 24,
    parameter int SEQ_STEP = 8
) (
    input  logic [ADDR_W-1:0] addr_word,
    input  logic [ADDR_W-1:0] script_ptr,
    input  logic              rel_mode,
    input  logic              fail,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset_sx;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_tgt;

    always_comb begin
        offset_sx = {{EXT_W{addr_word[OFF_W-1]}}, addr_word[OFF_W-1:0]};
        rel_tgt   = script_ptr + offset_sx;
        seq_addr  = script_ptr + ADDR_W'(SEQ_STEP);
        br_tgt    = rel_mode ? rel_tgt : addr_word;
        next_addr = fail ? br_tgt : seq_addr;
    end
endmodule

// File: rtl/ctl_line_exec.sv
module ctl_line_exec
    import ctl_exec_pkg::*;
#(
    parameter int OFF_W    = 24,
    parameter int SEQ_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic              op_set_i,
    input  logic [CTL_W-1:0]  ctl_bits_i,
    input  logic [ADDR_W-1:0] addr_word_i,
    input  logic              rel_mode_i,
    input  logic [ADDR_W-1:0] script_ptr_i,
    input  logic              fail_i,
    input  logic              initiator_i,
    input  logic              loopback_i,
    output logic              ack_n_o,
    output logic              atn_n_o,
    output logic              latch_ack_o,
    output logic              latch_atn_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              done_o
);
    exec_state_t       st_d, st_q;
    line_vec_t         latch_nxt;
    line_vec_t         bus_n;
    logic [ADDR_W-1:0] addr_nxt;

    ctl_latch_upd u_latch (
        .ctl_bits (ctl_bits_i),
        .op_set   (op_set_i),
        .apply    (exec_i),
        .cur      (st_q.latch),
        .nxt      (latch_nxt)
    );

    branch_addr_calc #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .SEQ_STEP (SEQ_STEP)
    ) u_addr (
        .addr_word  (addr_word_i),
        .script_ptr (script_ptr_i),
        .rel_mode   (rel_mode_i),
        .fail       (fail_i),
        .next_addr  (addr_nxt)
    );

    bus_drv_gate u_gate (
        .latch     (st_q.latch),
        .initiator (initiator_i),
        .loopback  (loopback_i),
        .bus_n     (bus_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.latch = latch_nxt;
        st_d.done  = exec_i;
        if (exec_i) begin
            st_d.next_addr = addr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_n_o     = bus_n[LN_ACK];
    assign atn_n_o     = bus_n[LN_ATN];
    assign latch_ack_o = st_q.latch[LN_ACK];
    assign latch_atn_o = st_q.latch[LN_ATN];
    assign next_addr_o = st_q.next_addr;
    assign done_o      = st_q.done;
endmodule

// File: rtl/ctl_line_exec_chk.sv
module ctl_line_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_i,
    input logic        op_set_i,
    input logic [8:0]  ctl_bits_i,
    input logic [31:0] script_ptr_i,
    input logic        fail_i,
    input logic        initiator_i,
    input logic        loopback_i,
    input logic        ack_n_o,
    input logic        atn_n_o,
    input logic        latch_ack_o,
    input logic        latch_atn_o,
    input logic [31:0] next_addr_o,
    input logic        done_o
);
    // R7
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> done_o);
    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> !done_o);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(latch_ack_o) && $stable(latch_atn_o) && $stable(next_addr_o)));
    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(initiator_i || loopback_i) |-> (ack_n_o && atn_n_o));
    // R6
    drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (initiator_i || loopback_i) |-> (ack_n_o == !latch_ack_o && atn_n_o == !latch_atn_o));
    // R2
    set_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_set_i && ctl_bits_i[6]) |=> latch_ack_o);
    // R2
    set_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_set_i && ctl_bits_i[3]) |=> latch_atn_o);
    // R3
    clr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !op_set_i && ctl_bits_i[6]) |=> !latch_ack_o);
    // R3
    clr_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !op_set_i && ctl_bits_i[3]) |=> !latch_atn_o);
    // R4
    keep_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !ctl_bits_i[6]) |=> $stable(latch_ack_o));
    // R4
    keep_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !ctl_bits_i[3]) |=> $stable(latch_atn_o));
    // R10
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !fail_i) |=> (next_addr_o == $past(script_ptr_i) + 32'd8));
endmodule

bind ctl_line_exec ctl_line_exec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec_i),
    .op_set_i     (op_set_i),
    .ctl_bits_i   (ctl_bits_i),
    .script_ptr_i (script_ptr_i),
    .fail_i       (fail_i),
    .initiator_i  (initiator_i),
    .loopback_i   (loopback_i),
    .ack_n_o      (ack_n_o),
    .atn_n_o      (atn_n_o),
    .latch_ack_o  (latch_ack_o),
    .latch_atn_o  (latch_atn_o),
    .next_addr_o  (next_addr_o),
    .done_o       (done_o)
);

// File: tb/ctl_line_exec_test.sv
`timescale 1ns/1ps
module ctl_line_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic        op_set_i = 1'b0;
    logic [8:0]  ctl_bits_i = '0;
    logic [31:0] addr_word_i = '0;
    logic        rel_mode_i = 1'b0;
    logic [31:0] script_ptr_i = '0;
    logic        fail_i = 1'b0;
    logic        initiator_i = 1'b0;
    logic        loopback_i = 1'b0;
    logic        ack_n_o, atn_n_o, latch_ack_o, latch_atn_o, done_o;
    logic [31:0] next_addr_o;

    int n_run = 0;
    int n_fail = 0;
    logic m_ack = 1'b0;
    logic m_atn = 1'b0;
    logic [31:0] m_addr = '0;

    always #2.5 clk = ~clk;

    ctl_line_exec uut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_set_i(op_set_i),
        .ctl_bits_i(ctl_bits_i), .addr_word_i(addr_word_i), .rel_mode_i(rel_mode_i),
        .script_ptr_i(script_ptr_i), .fail_i(fail_i), .initiator_i(initiator_i),
        .loopback_i(loopback_i), .ack_n_o(ack_n_o), .atn_n_o(atn_n_o),
        .latch_ack_o(latch_ack_o), .latch_atn_o(latch_atn_o),
        .next_addr_o(next_addr_o), .done_o(done_o)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] w, logic [31:0] p,
                                             logic rel, logic f);
        if (!f) return p + 32'd8;
        if (!rel) return w;
        return p + {{8{w[23]}}, w[23:0]};
    endfunction

    function automatic logic exp_line(logic cur, logic sel, logic set);
        return sel ? set : cur;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bus(string req);
        logic en;
        en = initiator_i | loopback_i;
        chk(req, {31'd0, ack_n_o}, {31'd0, ~(m_ack & en)});
        chk(req, {31'd0, atn_n_o}, {31'd0, ~(m_atn & en)});
    endtask

    // drive at negedge, strobe for one edge, check at the following negedge
    task automatic run_instr(logic set, logic [8:0] ctl, logic [31:0] w,
                             logic [31:0] p, logic rel, logic f, string req);
        @(negedge clk);
        exec_i = 1'b1; op_set_i = set; ctl_bits_i = ctl; addr_word_i = w;
        script_ptr_i = p; rel_mode_i = rel; fail_i = f;
        m_ack  = exp_line(m_ack, ctl[6], set);
        m_atn  = exp_line(m_atn, ctl[3], set);
        m_addr = exp_addr(w, p, rel, f);
        @(negedge clk);
        exec_i = 1'b0;
        chk({req, " latch_ack"}, {31'd0, latch_ack_o}, {31'd0, m_ack});
        chk({req, " latch_atn"}, {31'd0, latch_atn_o}, {31'd0, m_atn});
        chk({req, " next_addr"}, next_addr_o, m_addr);
        chk("R7 done high", {31'd0, done_o}, 32'd1);
        chk_bus({req, " R6 bus"});
        @(negedge clk);
        chk("R7 done low", {31'd0, done_o}, 32'd0);
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 latch", {30'd0, latch_ack_o, latch_atn_o}, 32'd0);
        chk("R1 bus", {30'd0, ack_n_o, atn_n_o}, 32'd3);
        chk("R1 done", {31'd0, done_o}, 32'd0);
        chk("R1 addr", next_addr_o, 32'd0);
        rst_n = 1'b1;
        initiator_i = 1'b1;
        @(negedge clk);

        // R2 set both lines in one instruction
        run_instr(1'b1, 9'h048, 32'h1000, 32'h200, 1'b0, 1'b0, "R2 R10");
        // R3 clear both
        run_instr(1'b0, 9'h048, 32'h1000, 32'h200, 1'b0, 1'b0, "R3");
        // R4 reserved bits only: no change
        run_instr(1'b1, 9'h1B7, 32'hDEAD_BEEF, 32'h300, 1'b0, 1'b1, "R4 R8");
        // R11 set ATN, then clear ACK
        run_instr(1'b1, 9'h040, 32'h0, 32'h400, 1'b0, 1'b0, "R11 pre");
        run_instr(1'b1, 9'h008, 32'h0, 32'h408, 1'b0, 1'b0, "R11 atn");
        run_instr(1'b0, 9'h040, 32'h0, 32'h410, 1'b0, 1'b0, "R11 ack");
        chk("R11 atn asserted", {31'd0, atn_n_o}, 32'd0);
        chk("R11 ack released", {31'd0, ack_n_o}, 32'd1);
        // R9 negative offset wraps below zero, positive wraps over top
        run_instr(1'b0, 9'h000, 32'hAB80_0000, 32'h0000_0010, 1'b1, 1'b1, "R9 neg");
        run_instr(1'b0, 9'h000, 32'h0000_0100, 32'hFFFF_FF80, 1'b1, 1'b1, "R9 pos");
        // R10 sequential wrap
        run_instr(1'b0, 9'h000, 32'h0, 32'hFFFF_FFFC, 1'b1, 1'b0, "R10 wrap");
        // R6 gated off: latch updates, bus stays released
        initiator_i = 1'b0; loopback_i = 1'b0;
        run_instr(1'b1, 9'h048, 32'h0, 32'h0, 1'b0, 1'b0, "R6 off");
        chk("R6 gated", {30'd0, ack_n_o, atn_n_o}, 32'd3);
        loopback_i = 1'b1;
        @(negedge clk);
        chk_bus("R6 loopback");

        // R5 idle cycles hold
        @(negedge clk);
        addr_word_i = 32'h5555_5555; ctl_bits_i = 9'h1FF; script_ptr_i = 32'h77;
        repeat (3) @(negedge clk);
        chk("R5 ack hold", {31'd0, latch_ack_o}, {31'd0, m_ack});
        chk("R5 atn hold", {31'd0, latch_atn_o}, {31'd0, m_atn});
        chk("R5 addr hold", next_addr_o, m_addr);

        // random mix
        for (int i = 0; i < 300; i++) begin
            initiator_i = 1'($urandom);
            loopback_i  = 1'($urandom);
            run_instr(1'($urandom), 9'($urandom), $urandom, $urandom,
                      1'($urandom), 1'($urandom), "R2 R3 R4 R8 R9 R10 rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule